// File: doc/BRIEF.md
# Interrupt Source Routing Register Bank

This block holds the configuration words for a set of interrupt sources and steers each active source onto per-CPU interrupt lines. Software reaches it through a 32-bit, word-access register bus with a single-cycle strobe. Each source owns a 32-byte slot holding three registers: a vector/priority word whose top bit masks the source, a destination word that is a bitmap with one bit per CPU, and a class word that picks one of three output classes: normal, critical or machine check.

Low-numbered sources are edge-triggered. A rising input latches a pending bit, and a per-source clear strobe drops it. Sources from a configurable base upward are level-sensitive and are pending for as long as their input is high. When a source is pending and unmasked, the block raises the line of its class on every CPU whose destination bit is set. A fixed summary window in the same address space reads as zero and ignores writes. A parameter removes the class register, and every source is then routed as a normal interrupt.

Top module: `irq_route_bank`

## Requirements
- R1: The source index is the bus byte address shifted right by 5. Slot offset 0x00 holds the vector/priority word, 0x10 the destination word and 0x18 the class word. The first two store all 32 written bits and read them back unchanged.
- R2: A read of any other offset in a slot, of a slot index at or above NUM_SRC, or of an address outside both the slots and the summary window returns 0xFFFFFFFF. A write to any of these changes nothing.
- R3: Out of reset, every vector/priority word is 0x80000000 (masked), every destination word is 0x00000001 (CPU 0 only) and every class word reads 0x00.
- R4: The class comes from the low 8 bits of a write to offset 0x18: 0x01 selects critical, 0x02 machine check, and any other value normal. A read returns the stored class code (0, 1 or 2) with all upper bits zero.
- R5: With LEVEL_EN = 0, reads of offset 0x18 return 0xFFFFFFFF, writes to it have no effect, and every source is routed as normal.
- R6: Sources below NUM_EDGE are edge sources. An input that is high in a cycle after being low in the previous cycle sets the pending bit at that clock edge. The bit stays set until a clock edge with that source's pend_clr bit high. If a rising input and a clear arrive at the same edge, the set wins.
- R7: Sources at or above LEVEL_BASE are pending exactly while their input is high. Sources from NUM_EDGE to LEVEL_BASE-1 are never pending.
- R8: When bit 31 of the vector/priority word is set, the source drives no output. An edge source's pending bit is still kept while masked, and the source drives its outputs again as soon as it is unmasked.
- R9: A pending, unmasked source raises the line of its class for every CPU c < NUM_CPU whose destination bit c is set. Destination bits at or above NUM_CPU have no effect. Each line is the OR over all sources. Outputs are combinational from the registers and the level inputs, so a register write takes effect right after the clock edge that stores it.
- R10: Byte addresses 0x3800 to 0x3FFF read as 0 and ignore writes.
- R11: bus_rdata is combinational and valid in any cycle with bus_en high and bus_we low. It is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| src_in | input | NUM_SRC | Raw interrupt inputs |
| pend_clr | input | NUM_SRC | Per-source clear strobe for edge pending bits |
| irq_norm_o | output | NUM_CPU | Normal interrupt line per CPU |
| irq_crit_o | output | NUM_CPU | Critical interrupt line per CPU |
| irq_mchk_o | output | NUM_CPU | Machine-check line per CPU |

## Verification
The bench tests the class decode with out-of-range codes such as 0x07 and 0x102. A design that stored the raw byte, or decoded more than 8 bits, would read back a wrong code or raise the wrong line. It also tests masking while an edge bit is pending, a rising input and a clear at the same edge, the reserved sources between the edge and level ranges, and destination bits above the CPU count. Each of these shows up as a lost pending bit, a spurious output or a stuck output. Finally, it hits the holes and edges of the address space: in-slot offsets that decode nothing, the slot just past the last source, the summary window and the region above it. Any of these that aliased onto a real slot would corrupt stored state or return the wrong read value.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [1:0] {
    CLS_NORM = 2'd0,
    CLS_CRIT = 2'd1,
    CLS_MCHK = 2'd2
  } irq_class_e;

  typedef enum logic [1:0] {
    KIND_EDGE  = 2'd0,
    KIND_LEVEL = 2'd1,
    KIND_NONE  = 2'd2
  } src_kind_e;

  localparam logic [4:0]  OFS_VP   = 5'h00;
  localparam logic [4:0]  OFS_DEST = 5'h10;
  localparam logic [4:0]  OFS_LVL  = 5'h18;
  localparam logic [31:0] SUM_LO   = 32'h0000_3800;
  localparam logic [31:0] SUM_HI   = 32'h0000_4000;
  localparam logic [31:0] WORD_ONES = 32'hFFFF_FFFF;
  localparam logic [31:0] VP_RESET   = 32'h8000_0000;
  localparam logic [31:0] DEST_RESET = 32'h0000_0001;

  function automatic irq_class_e code_to_class(input logic [7:0] code);
    case (code)
      8'h01:   return CLS_CRIT;
      8'h02:   return CLS_MCHK;
      default: return CLS_NORM;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_route_pkg::*;
#(
  parameter src_kind_e KIND     = KIND_EDGE,
  parameter bit        LEVEL_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_in,
  input  logic        pend_clr,
  input  logic        wr_vp,
  input  logic        wr_dest,
  input  logic        wr_lvl,
  input  logic [31:0] wdata,
  output logic [31:0] vp_o,
  output logic [31:0] dest_o,
  output irq_class_e  cls_o,
  output logic        fire_o
);

  logic [31:0] vp_q, vp_d;
  logic [31:0] dest_q, dest_d;
  irq_class_e  cls_q, cls_d;
  logic        pend_q, pend_d;
  logic        prev_q;
  logic        rise;
  logic        active;

  assign rise = src_in & ~prev_q;

  always_comb begin
    vp_d   = vp_q;
    dest_d = dest_q;
    cls_d  = cls_q;
    if (wr_vp)             vp_d   = wdata;
    if (wr_dest)           dest_d = wdata;
    if (LEVEL_EN && wr_lvl) cls_d = code_to_class(wdata[7:0]);
    pend_d = rise | (pend_q & ~pend_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp_q   <= VP_RESET;
      dest_q <= DEST_RESET;
      cls_q  <= CLS_NORM;
      pend_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      vp_q   <= vp_d;
      dest_q <= dest_d;
      cls_q  <= cls_d;
      pend_q <= pend_d;
      prev_q <= src_in;
    end
  end

  always_comb begin
    case (KIND)
      KIND_EDGE:  active = pend_q;
      KIND_LEVEL: active = src_in;
      default:    active = 1'b0;
    endcase
  end

  assign fire_o = active & ~vp_q[31];
  assign vp_o   = vp_q;
  assign dest_o = dest_q;
  assign cls_o  = cls_q;

  assert_vp_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vp |=> (vp_q[31] == $past(wdata[31])));

  assert_bad_code_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (LEVEL_EN && wr_lvl && (wdata[7:0] > 8'h02)) |=> (cls_q == CLS_NORM));

  assert_edge_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in && !prev_q) |=> pend_q);

  assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_clr && !(src_in && !prev_q)) |=> !pend_q);

endmodule

// File: rtl/irq_route_fanout.sv
module irq_route_fanout
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int NUM_CPU = 4
) (
  input  logic [NUM_SRC-1:0] fire,
  input  irq_class_e         cls  [NUM_SRC],
  input  logic [NUM_CPU-1:0] dest [NUM_SRC],
  output logic [NUM_CPU-1:0] norm_o,
  output logic [NUM_CPU-1:0] crit_o,
  output logic [NUM_CPU-1:0] mchk_o
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic n_l, c_l, m_l;

    always_comb begin
      n_l = 1'b0;
      c_l = 1'b0;
      m_l = 1'b0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (fire[s] && dest[s][c]) begin
          case (cls[s])
            CLS_CRIT: c_l = 1'b1;
            CLS_MCHK: m_l = 1'b1;
            default:  n_l = 1'b1;
          endcase
        end
      end
    end

    assign norm_o[c] = n_l;
    assign crit_o[c] = c_l;
    assign mchk_o[c] = m_l;
  end

endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC    = 24,
  parameter int NUM_CPU    = 4,
  parameter int NUM_EDGE   = 12,
  parameter int LEVEL_BASE = 16,
  parameter int ADDR_W     = 16,
  parameter bit LEVEL_EN   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] pend_clr,
  output logic [NUM_CPU-1:0] irq_norm_o,
  output logic [NUM_CPU-1:0] irq_crit_o,
  output logic [NUM_CPU-1:0] irq_mchk_o
);

  localparam int IDX_W = ADDR_W - 5;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [IDX_W-1:0] slot_idx;
  logic [4:0]       slot_ofs;
  logic [31:0]      addr_w;
  logic             in_sum, slot_ok, wr_hit, rd_req;

  assign slot_idx = bus_addr[ADDR_W-1:5];
  assign slot_ofs = bus_addr[4:0];
  assign addr_w   = 32'(bus_addr);
  assign in_sum   = (addr_w >= SUM_LO) && (addr_w < SUM_HI);
  assign slot_ok  = !in_sum && (32'(slot_idx) < 32'(NUM_SRC));
  assign wr_hit   = bus_en && bus_we && slot_ok;
  assign rd_req   = bus_en && !bus_we;

  logic [31:0]        vp_w   [NUM_SRC];
  logic [31:0]        dest_w [NUM_SRC];
  logic [NUM_CPU-1:0] dest_c [NUM_SRC];
  irq_class_e         cls_w  [NUM_SRC];
  logic [NUM_SRC-1:0] fire_w;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam src_kind_e K = (s < NUM_EDGE)    ? KIND_EDGE :
                              (s >= LEVEL_BASE) ? KIND_LEVEL : KIND_NONE;
    logic sel;
    assign sel = wr_hit && (slot_idx == IDX_W'(s));

    irq_src_slot #(
      .KIND     (K),
      .LEVEL_EN (LEVEL_EN)
    ) i_slot (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .src_in   (src_in[s]),
      .pend_clr (pend_clr[s]),
      .wr_vp    (sel && (slot_ofs == OFS_VP)),
      .wr_dest  (sel && (slot_ofs == OFS_DEST)),
      .wr_lvl   (sel && (slot_ofs == OFS_LVL)),
      .wdata    (bus_wdata),
      .vp_o     (vp_w[s]),
      .dest_o   (dest_w[s]),
      .cls_o    (cls_w[s]),
      .fire_o   (fire_w[s])
    );

    assign dest_c[s] = dest_w[s][NUM_CPU-1:0];
  end

  irq_route_fanout #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU)
  ) i_fanout (
    .fire   (fire_w),
    .cls    (cls_w),
    .dest   (dest_c),
    .norm_o (irq_norm_o),
    .crit_o (irq_crit_o),
    .mchk_o (irq_mchk_o)
  );

  logic [31:0] sel_vp, sel_dest;
  irq_class_e  sel_cls;

  always_comb begin
    sel_vp   = '0;
    sel_dest = '0;
    sel_cls  = CLS_NORM;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (slot_idx == IDX_W'(s)) begin
        sel_vp   = vp_w[s];
        sel_dest = dest_w[s];
        sel_cls  = cls_w[s];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_req && !in_sum) begin
      if (!slot_ok) begin
        bus_rdata = WORD_ONES;
      end else begin
        case (slot_ofs)
          OFS_VP:   bus_rdata = sel_vp;
          OFS_DEST: bus_rdata = sel_dest;
          OFS_LVL:  bus_rdata = LEVEL_EN ? 32'(sel_cls) : WORD_ONES;
          default:  bus_rdata = WORD_ONES;
        endcase
      end
    end
  end

  assert_lvl_readback_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (LEVEL_EN && rd_req && slot_ok && (slot_ofs == OFS_LVL)) |-> (bus_rdata <= 32'd2));

  assert_summary_zero_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en && in_sum) |-> (bus_rdata == 32'd0));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_en |-> (bus_rdata == 32'd0));

endmodule

// File: tb/test_irq_route_bank.sv
module test_irq_route_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 24;
  localparam int NCPU  = 4;
  localparam int NEDGE = 12;
  localparam int LBASE = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             en, we;
  logic [15:0]      addr;
  logic [31:0]      wdata, rdata;
  logic [NSRC-1:0]  src, clr;
  logic [NCPU-1:0]  o_norm, o_crit, o_mchk;

  logic             b_en, b_we;
  logic [15:0]      b_addr;
  logic [31:0]      b_wdata, b_rdata;
  logic [NSRC-1:0]  b_src, b_clr;
  logic [NCPU-1:0]  b_norm, b_crit, b_mchk;

  irq_route_bank i_irq_route_bank (
    .clk(clk), .rst_n(rst_n), .bus_en(en), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .src_in(src), .pend_clr(clr),
    .irq_norm_o(o_norm), .irq_crit_o(o_crit), .irq_mchk_o(o_mchk));

  irq_route_bank #(.LEVEL_EN(1'b0)) i_irq_route_bank_nolvl (
    .clk(clk), .rst_n(rst_n), .bus_en(b_en), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .src_in(b_src), .pend_clr(b_clr),
    .irq_norm_o(b_norm), .irq_crit_o(b_crit), .irq_mchk_o(b_mchk));

  int n_cmp = 0;
  int n_bad = 0;

  bit [31:0] m_vp [NSRC];
  bit [31:0] m_dest [NSRC];
  int        m_cls [NSRC];
  bit        m_pend [NSRC];
  bit        m_prev [NSRC];

  function automatic int dec_code(input logic [31:0] d);
    if (d[7:0] == 8'h01) return 1;
    if (d[7:0] == 8'h02) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] exp_rdata();
    int a = int'(addr);
    int idx = a >> 5;
    int ofs = a & 31;
    if (!(en && !we)) return 32'd0;
    if (a >= 'h3800 && a < 'h4000) return 32'd0;
    if (idx >= NSRC) return 32'hFFFF_FFFF;
    case (ofs)
      0:  return m_vp[idx];
      16: return m_dest[idx];
      24: return 32'(m_cls[idx]);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [NCPU-1:0] exp_line(input int cl);
    logic [NCPU-1:0] r = '0;
    for (int s = 0; s < NSRC; s++) begin
      bit act = (s < NEDGE) ? m_pend[s] : (s >= LBASE) ? src[s] : 1'b0;
      if (act && !m_vp[s][31] && m_cls[s] == cl)
        for (int c = 0; c < NCPU; c++) if (m_dest[s][c]) r[c] = 1'b1;
    end
    return r;
  endfunction

  task automatic model_update();
    for (int s = 0; s < NSRC; s++) begin
      bit rise = src[s] & ~m_prev[s];
      if (s < NEDGE) m_pend[s] = rise | (m_pend[s] & ~clr[s]);
      m_prev[s] = src[s];
    end
    if (en && we) begin
      int a = int'(addr);
      if (!(a >= 'h3800 && a < 'h4000) && (a >> 5) < NSRC) begin
        case (a & 31)
          0:  m_vp[a >> 5]   = wdata;
          16: m_dest[a >> 5] = wdata;
          24: m_cls[a >> 5]  = dec_code(wdata);
          default: ;
        endcase
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rdata", rdata, exp_rdata());
    chk(tag, "norm", 32'(o_norm), 32'(exp_line(0)));
    chk(tag, "crit", 32'(o_crit), 32'(exp_line(1)));
    chk(tag, "mchk", 32'(o_mchk), 32'(exp_line(2)));
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    tick(tag);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    en = 1'b1; we = 1'b0; addr = a;
    tick(tag);
    en = 1'b0;
  endtask

  function automatic logic [15:0] sa(input int s, input int ofs);
    return 16'(s * 32 + ofs);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < NSRC; s++) begin
      m_vp[s] = 32'h8000_0000; m_dest[s] = 32'h1; m_cls[s] = 0;
      m_pend[s] = 1'b0; m_prev[s] = 1'b0;
    end
    rst_n = 1'b0; en = 0; we = 0; addr = 0; wdata = 0; src = 0; clr = 0;
    b_en = 0; b_we = 0; b_addr = 0; b_wdata = 0; b_src = 0; b_clr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R3 reset values, R11 idle read data
    tick("R11");
    for (int s = 0; s < NSRC; s += 11) begin
      rd(sa(s, 0), "R3");
      en = 1; addr = sa(s, 0); #1 chk("R3", "vp reset", rdata, 32'h8000_0000);
      addr = sa(s, 16);        #1 chk("R3", "dest reset", rdata, 32'h1);
      addr = sa(s, 24);        #1 chk("R3", "lvl reset", rdata, 32'h0);
      en = 0;
      rd(sa(s, 16), "R3");
      rd(sa(s, 24), "R3");
    end

    // R1 register access on source 3
    wr(sa(3, 0), 32'h0000_0A05, "R1");
    wr(sa(3, 16), 32'h0000_000A, "R1");
    wr(sa(3, 24), 32'h0000_0001, "R1");
    rd(sa(3, 0), "R1"); rd(sa(3, 16), "R1"); rd(sa(3, 24), "R1");

    // R6 edge latching and clearing
    src[3] = 1; tick("R6");
    src[3] = 0; tick("R6"); tick("R6");
    clr[3] = 1; tick("R6");
    clr[3] = 0; tick("R6");
    src[3] = 1; clr[3] = 1; tick("R6");
    clr[3] = 0; tick("R6");
    en = 1; addr = 0; #1 chk("R6", "crit after set-wins", 32'(o_crit), 32'h0000_000A);
    en = 0;

    // R8 masking keeps pending bit
    wr(sa(3, 0), 32'h8000_0A05, "R8");
    tick("R8");
    wr(sa(3, 0), 32'h0000_0A05, "R8");
    src[3] = 0; clr[3] = 1; tick("R8"); clr[3] = 0; tick("R8");

    // R7 level source 18, reserved source 13
    wr(sa(18, 0), 32'h0, "R7");
    wr(sa(18, 16), 32'h5, "R7");
    wr(sa(18, 24), 32'h2, "R7");
    src[18] = 1; tick("R7"); tick("R7");
    src[18] = 0; tick("R7");
    wr(sa(13, 0), 32'h0, "R7");
    src[13] = 1; tick("R7"); tick("R7");
    src[13] = 0; tick("R7");

    // R4 class code decode
    src[18] = 1;
    wr(sa(18, 24), 32'h0000_0007, "R4"); rd(sa(18, 24), "R4");
    wr(sa(18, 24), 32'h0000_0102, "R4"); rd(sa(18, 24), "R4");
    wr(sa(18, 24), 32'hFFFF_FF01, "R4"); rd(sa(18, 24), "R4");

    // R9 fan-out: dest bit above NUM_CPU, OR across sources, empty dest
    wr(sa(18, 16), 32'h8000_0002, "R9");
    wr(sa(20, 0), 32'h0, "R9");
    wr(sa(20, 16), 32'h0000_0003, "R9");
    src[20] = 1; tick("R9");
    wr(sa(20, 24), 32'h1, "R9");
    wr(sa(20, 16), 32'h0, "R9");
    src[18] = 0; src[20] = 0; tick("R9");

    // R2 holes in the address space
    wr(sa(3, 4), 32'h1234_5678, "R2");
    wr(sa(3, 20), 32'h0, "R2");
    wr(sa(3, 28), 32'h2, "R2");
    wr(sa(24, 0), 32'h0, "R2");
    wr(16'h4000, 32'h0, "R2");
    rd(sa(3, 4), "R2"); rd(sa(3, 20), "R2"); rd(sa(3, 28), "R2");
    rd(sa(24, 0), "R2"); rd(16'h4000, "R2"); rd(sa(3, 0), "R2");

    // R10 summary window
    wr(16'h3800, 32'hFFFF_FFFF, "R10");
    wr(16'h3FFC, 32'hFFFF_FFFF, "R10");
    rd(16'h3800, "R10"); rd(16'h3A10, "R10"); rd(16'h3FFC, "R10"); rd(16'h37FC, "R10");

    // R5 second instance without class register
    b_en = 1; b_we = 1; b_addr = sa(16, 0); b_wdata = 32'h5; tick("R5");
    b_addr = sa(16, 24); b_wdata = 32'h1; tick("R5");
    b_we = 0; b_src[16] = 1; tick("R5");
    chk("R5", "lvl read", b_rdata, 32'hFFFF_FFFF);
    chk("R5", "norm", 32'(b_norm), 32'h1);
    chk("R5", "crit", 32'(b_crit), 32'h0);
    b_en = 0; b_src[16] = 0;

    // R9 randomised mix
    for (int i = 0; i < 400; i++) begin
      int pick = $urandom % 5;
      int s = (pick == 0) ? 3 : (pick == 1) ? 18 : (pick == 2) ? 13 : (pick == 3) ? 0 : 21;
      int o = ($urandom % 4) * 8;
      en = ($urandom % 3) != 0;
      we = $urandom % 2;
      addr = sa(s, (o == 8) ? 16 : o);
      wdata = (o == 24) ? 32'($urandom % 4) : {$urandom % 2 == 0, 27'd0, 4'($urandom)};
      src = NSRC'($urandom);
      clr = NSRC'($urandom) & NSRC'($urandom);
      tick("R9");
    end
    en = 0; we = 0; src = 0; clr = 0;
    tick("R9");

    summary();
    $finish;
  end

endmodule